// File: doc/BRIEF.md
# Score RAM Change Tracker

This block sits beside a 2 KB battery-backed RAM that holds saved scores and tells the host when that RAM holds something new enough to be saved. It watches bus writes. A write is taken only when its address falls in the 2 KB window from 0x1000 to 0x17FF. The block captures the write together with the byte the RAM returns for that address. One cycle later it commits the write to the RAM, but only if the new byte differs from the stored one.

A committed write raises a sticky dirty flag. Two kinds of location do not raise the flag: the scratch location at 0x1007 and the tail locations from 0x17FA to 0x17FF. Writes to these locations still update the RAM. The flag stays set until the host pulses the clear input. The host then saves the RAM contents.

A write to the same location in the very next cycle would read a stale byte from the RAM. In that case the block compares against the byte it is committing at that moment instead.

Top module: `score_ram_dirty_tracker`

## Requirements
- R1: A write strobe is accepted only when address bits [15:11] equal 5'b00010 (window 0x1000 to 0x17FF). Writes outside the window never raise `ram_we` and never change `dirty`.
- R2: An accepted write whose data differs from `rdata` raises `ram_we` for exactly the cycle after the strobe. In that cycle `ram_addr` equals address bits [10:0] and `ram_wdata` equals the write data.
- R3: An accepted write whose data equals `rdata` raises no `ram_we` and leaves `dirty` unchanged.
- R4: In the cycle after a `ram_we` cycle, `dirty` reads 1 when the committed offset is neither 0x007 nor at or above 0x7FA.
- R5: A committed write to 0x1007 updates the RAM but does not set `dirty`.
- R6: Committed writes to 0x17FA through 0x17FF do not set `dirty`; a committed write to 0x17F9 does.
- R7: Once set, `dirty` holds until `clr` is high at a clock edge, after which it reads 0.
- R8: When a flag-setting commit and `clr` coincide at the same edge, `dirty` reads 1 afterwards.
- R9: After reset, `dirty` and `ram_we` read 0.
- R10: When a write commits in the same cycle that a new strobe arrives for the same address, the new write is compared against the committing data rather than against `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address of the write |
| wdata | input | 8 | Bus write data |
| wr_en | input | 1 | Write strobe |
| rdata | input | 8 | Byte currently stored at `addr`, returned by the RAM |
| clr | input | 1 | Host pulse that clears the dirty flag |
| ram_we | output | 1 | RAM write enable for the committing write |
| ram_addr | output | 11 | Offset inside the window of the committing write |
| ram_wdata | output | 8 | Data of the committing write |
| dirty | output | 1 | Sticky flag: window contents changed since the last clear |

## Verification
The bench sweeps every offset of the window with a mix of equal and differing read-back bytes. This sweep catches a design that commits unchanged bytes, or one that misplaces the exclusions by a single location at 0x1007 or at the 0x17F9/0x17FA edge. The bench also probes every other 2 KB region of the address space: a loose window decode would write the RAM from an alias. Back-to-back writes to one address check that forwarding suppresses a repeat write, and a different second address checks that forwarding is not applied where it does not belong. A clear pulse that coincides with a flag-setting commit exposes a design that lets the clear win.

// File: rtl/score_ram_dirty_tracker.sv
module score_ram_dirty_tracker #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int OW         = 11,
  parameter int WIN_BASE   = 'h1000,
  parameter int SKIP_ADDR  = 'h1007,
  parameter int TAIL_START = 'h17FA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic [DW-1:0] rdata,
  input  logic          clr,
  output logic          ram_we,
  output logic [OW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          dirty
);
  localparam logic [AW-1:0] BASE_V = AW'(WIN_BASE);
  localparam logic [OW-1:0] SKIP_O = OW'(SKIP_ADDR);
  localparam logic [OW-1:0] TAIL_O = OW'(TAIL_START);

  logic          in_win, p_vld, flag_ok;
  logic [DW-1:0] old_byte, p_old;

  assign in_win   = (addr[AW-1:OW] == BASE_V[AW-1:OW]);
  assign old_byte = (ram_we && ram_addr == addr[OW-1:0]) ? ram_wdata : rdata;
  assign ram_we   = p_vld && (ram_wdata != p_old);
  assign flag_ok  = (ram_addr != SKIP_O) && (ram_addr < TAIL_O);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld     <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      p_old     <= '0;
      dirty     <= 1'b0;
    end else begin
      p_vld     <= wr_en && in_win;
      ram_addr  <= addr[OW-1:0];
      ram_wdata <= wdata;
      p_old     <= old_byte;
      dirty     <= (ram_we && flag_ok) || (dirty && !clr);
    end
  end

  a_r1_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(wr_en) && $past(addr[AW-1:OW]) == BASE_V[AW-1:OW]));
  a_r2_commit_data: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata == $past(wdata) && ram_addr == $past(addr[OW-1:0])));
  a_r4_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr != SKIP_O && ram_addr < TAIL_O) |=> dirty);
  a_r5_skip_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == SKIP_O && !dirty) |=> !dirty);
  a_r6_tail_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr >= TAIL_O && !dirty) |=> !dirty);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty && !clr) |=> dirty);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!dirty && !ram_we) |=> !dirty);
endmodule

// File: tb/score_ram_dirty_tracker_tb.sv
module score_ram_dirty_tracker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata = '0;
  logic        wr_en = 1'b0, clr = 1'b0;
  logic        ram_we, dirty;
  logic [10:0] ram_addr;
  logic [7:0]  ram_wdata;

  int n_chk = 0, n_fail = 0;
  bit model_dirty = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  score_ram_dirty_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .clr(clr), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .dirty(dirty));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clr_mode: 0 none, 1 with strobe, 2 during commit cycle
  task automatic wr(logic [15:0] a, logic [7:0] d, logic [7:0] rd, int clr_mode, string req);
    bit win, exp_we, ok;
    win    = (a[15:11] == 5'b00010);
    exp_we = win && (d != rd);
    ok     = (a[10:0] != 11'h007) && (a[10:0] < 11'h7FA);
    @(negedge clk);
    addr = a; wdata = d; rdata = rd; wr_en = 1'b1; clr = (clr_mode == 1);
    if (clr_mode == 1) model_dirty = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; clr = (clr_mode == 2);
    chk({req, " ram_we"}, int'(ram_we), int'(exp_we));
    if (exp_we) begin
      chk({req, " ram_addr"}, int'(ram_addr), int'(a[10:0]));
      chk({req, " ram_wdata"}, int'(ram_wdata), int'(d));
    end
    if (exp_we && ok) model_dirty = 1'b1;
    else if (clr_mode == 2) model_dirty = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk({req, " dirty"}, int'(dirty), int'(model_dirty));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset dirty", int'(dirty), 0);
    chk("R9 reset ram_we", int'(ram_we), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6: full offset sweep, flag cleared with each strobe
    for (int off = 0; off < 2048; off++) begin
      logic [7:0] d;
      d = off[7:0] ^ 8'h5A;
      wr(16'h1000 + 16'(off), d, (off % 3 == 0) ? d : ~d, 1, "R4 sweep");
    end
    wr(16'h1007, 8'h11, 8'h22, 1, "R5 skip");
    wr(16'h17F9, 8'h11, 8'h22, 1, "R6 last flagged");
    wr(16'h17FA, 8'h11, 8'h22, 1, "R6 first tail");
    wr(16'h17FF, 8'h11, 8'h22, 1, "R6 last tail");
    wr(16'h1100, 8'h33, 8'h33, 1, "R3 equal");

    // R1: every other region, differing data, dirty must stay 0
    for (int hi = 0; hi < 32; hi++) begin
      if (hi != 2) begin
        wr({5'(hi), 11'h123}, 8'hA5, 8'h5A, 1, "R1 outside");
        wr({5'(hi), 11'h7FF}, 8'h01, 8'h02, 0, "R1 outside tail");
      end
    end

    // R7 sticky then clear
    wr(16'h1200, 8'h01, 8'h02, 1, "R7 set");
    repeat (5) @(negedge clk);
    chk("R7 sticky", int'(dirty), 1);
    wr(16'h1007, 8'h09, 8'h08, 0, "R7 hold on skip");
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    model_dirty = 1'b0;
    chk("R7 cleared", int'(dirty), 0);

    // R8 set beats clear
    wr(16'h1300, 8'h44, 8'h45, 2, "R8 set wins");
    chk("R8 set wins flag", int'(dirty), 1);
    wr(16'h17FC, 8'h44, 8'h45, 2, "R8 clear on tail commit");

    // R10 forwarding
    @(negedge clk);
    addr = 16'h1400; wdata = 8'hC3; rdata = 8'h3C; wr_en = 1'b1;
    @(negedge clk);
    chk("R10 first commit", int'(ram_we), 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 repeat suppressed", int'(ram_we), 0);
    @(negedge clk);
    addr = 16'h1400; wdata = 8'h10; rdata = 8'h20; wr_en = 1'b1;
    @(negedge clk);
    wdata = 8'h10; rdata = 8'h20;
    chk("R10 commit a", int'(ram_we), 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 repeat same suppressed", int'(ram_we), 0);
    @(negedge clk);
    addr = 16'h1400; wdata = 8'h10; rdata = 8'h20; wr_en = 1'b1;
    @(negedge clk);
    wdata = 8'h77;
    chk("R10 commit b", int'(ram_we), 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 new value commits", int'(ram_we), 1);
    chk("R10 new value data", int'(ram_wdata), 'h77);
    @(negedge clk);
    addr = 16'h1400; wdata = 8'h10; rdata = 8'h20; wr_en = 1'b1;
    @(negedge clk);
    addr = 16'h1401; wdata = 8'h10; rdata = 8'h20;
    chk("R10 commit c", int'(ram_we), 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 other addr not forwarded", int'(ram_we), 1);
    chk("R10 other addr offset", int'(ram_addr), 'h401);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule